// File: doc/BRIEF.md
# Two-Bank Addressed PWM Intensity Controller

This block drives sixteen on/off channel enables, split into two banks of eight, from one shared 10-bit ramp. Every channel owns a 10-bit duty word. A channel is on while the ramp is at or below its duty word and off once the ramp has passed it, so the duty word sets the on-time per ramp period.

A single update strobe carries a 3-bit channel number, one duty word for bank A, one for bank B and a 4-bit divisor code. The update writes the two same-numbered channels, one in each bank, in one step. The ramp does not step on every clock. It steps once per R pulses of a reference tick, where R is set by the divisor code. A force-off input, driven by supervisory logic such as a watchdog or a thermal monitor, blanks every output at once and leaves the stored settings untouched.

Top module: `pwm_dual_bank_ctrl`

## Requirements
- R1: After reset all duty words, the divisor and the ramp are zero, so with force-off low every one of the 16 enables is high (ramp 0 does not exceed duty 0).
- R2: A clock edge with `upd_valid` high writes `upd_duty_a` into bank-A channel `upd_addr` and `upd_duty_b` into bank-B channel `upd_addr`. The new value is visible on the enables right after that edge.
- R3: Channels not named by `upd_addr` keep their duty words across an update.
- R4: Channel i of a bank is enabled exactly when the ramp value is less than or equal to its duty word. Bit i of `chan_en_a`/`chan_en_b` is channel i. A duty of 1023 keeps the channel on for the whole period. A duty of 0 gives on-time only while the ramp is 0.
- R5: All 16 channels compare against one 10-bit ramp that counts up by one per step and wraps from 1023 to 0.
- R6: Every update also captures `upd_div`. With divisor code c in effect, the ramp steps once for every c+1 clock edges on which `ref_tick` is high. Code 0 steps on every tick and code 15 on every sixteenth.
- R7: A newly captured divisor takes effect only when the current prescale period finishes. A period already in progress keeps its old length, so no shortened step is produced.
- R8: While `force_off` is high all 16 enables are low in the same cycle. The duty words, the divisor and the ramp are unaffected, and outputs resume from the running ramp once it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference clock enable feeding the prescaler |
| upd_valid | input | 1 | Update strobe |
| upd_addr | input | 3 | Channel number written in both banks |
| upd_duty_a | input | 10 | Duty word for the addressed bank-A channel |
| upd_duty_b | input | 10 | Duty word for the addressed bank-B channel |
| upd_div | input | 4 | Divisor code, ratio = code + 1 |
| force_off | input | 1 | Blanks all outputs while high |
| chan_en_a | output | 8 | Bank-A channel enables |
| chan_en_b | output | 8 | Bank-B channel enables |

## Verification
The hardest case to reach is a divisor change that lands in the middle of a long prescale period while the reference tick arrives irregularly. To reach it, the bench feeds the tick from a pseudo-random sequence, captures code 15 partway through a period, and replaces it with a short code a few cycles later. A complete ramp wrap at the slowest ratio needs tens of thousands of cycles, so the bench runs long stretches of sparse ticks. On every cycle it compares all 16 enables against a behavioural ramp and prescaler model.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;
  parameter int DUTY_W      = 10;
  parameter int CH_PER_BANK = 8;
  parameter int DIV_W       = 4;
  parameter int NUM_BANKS   = 2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_in,
  output logic             adv
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] pend_q, pend_d;
  logic             term;

  always_comb begin
    pend_d = div_we ? div_in : pend_q;
    term   = ref_tick && (pre_q == act_q);
    act_d  = term ? pend_d : act_q;
    pre_d  = pre_q;
    if (ref_tick) begin
      pre_d = term ? '0 : pre_q + 1'b1;
    end
    adv = term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      act_q  <= '0;
      pend_q <= '0;
    end else begin
      pre_q  <= pre_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assert_pre_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= act_q);

  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(act_q));
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] ramp
);
  logic [W-1:0] ramp_q, ramp_d;

  always_comb begin
    ramp_d = ramp_q;
    if (adv) begin
      ramp_d = ramp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp_q <= '0;
    else        ramp_q <= ramp_d;
  end

  assign ramp = ramp_q;

  assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ramp_q == W'($past(ramp_q) + 1'b1));

  assert_ramp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ramp_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 8,
  parameter int W      = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_duty,
  input  logic [W-1:0]      ramp,
  input  logic              kill,
  output logic [NCH-1:0]    en
);
  logic [W-1:0] duty_q [NCH];
  logic [W-1:0] duty_d [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      duty_d[i] = duty_q[i];
      if (wr_en && (wr_addr == ADDR_W'(i))) begin
        duty_d[i] = wr_duty;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q[i] <= '0;
      else        duty_q[i] <= duty_d[i];
    end

    assign en[i] = !kill && (ramp <= duty_q[i]);

    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == ADDR_W'(i))) |=> $stable(duty_q[i]));

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(i))) |=> duty_q[i] == $past(wr_duty));
  end
endmodule

// File: rtl/pwm_dual_bank_ctrl.sv
module pwm_dual_bank_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int DW  = DUTY_W,
  parameter int NCH = CH_PER_BANK,
  parameter int DVW = DIV_W,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_tick,
  input  logic           upd_valid,
  input  logic [AW-1:0]  upd_addr,
  input  logic [DW-1:0]  upd_duty_a,
  input  logic [DW-1:0]  upd_duty_b,
  input  logic [DVW-1:0] upd_div,
  input  logic           force_off,
  output logic [NCH-1:0] chan_en_a,
  output logic [NCH-1:0] chan_en_b
);
  logic          adv;
  logic [DW-1:0] ramp;
  logic [NCH-1:0] bank_en [NUM_BANKS];

  pwm_prescale #(.DIV_W(DVW)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .div_we(upd_valid), .div_in(upd_div), .adv(adv)
  );

  pwm_ramp #(.W(DW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ramp(ramp)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pwm_bank #(.NCH(NCH), .W(DW), .ADDR_W(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(upd_valid), .wr_addr(upd_addr),
      .wr_duty((b == 0) ? upd_duty_a : upd_duty_b),
      .ramp(ramp), .kill(force_off), .en(bank_en[b])
    );
  end

  assign chan_en_a = bank_en[0];
  assign chan_en_b = bank_en[1];

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (chan_en_a == '0) && (chan_en_b == '0));

  assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_off && ramp == '0) |-> (chan_en_a == '1) && (chan_en_b == '1));
endmodule

// File: tb/pwm_dual_bank_ctrl_tb_top.sv
module pwm_dual_bank_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick;
  logic       upd_valid;
  logic [2:0] upd_addr;
  logic [9:0] upd_duty_a, upd_duty_b;
  logic [3:0] upd_div;
  logic       force_off;
  logic [7:0] chan_en_a, chan_en_b;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  int tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int m_duty [2][8];
  int m_cnt, m_pre, m_act, m_pend;

  always #10 clk = ~clk;

  pwm_dual_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_duty_a(upd_duty_a), .upd_duty_b(upd_duty_b),
    .upd_div(upd_div), .force_off(force_off),
    .chan_en_a(chan_en_a), .chan_en_b(chan_en_b)
  );

  task automatic compare();
    logic [7:0] ea, eb;
    for (int i = 0; i < 8; i++) begin
      ea[i] = !force_off && (m_cnt <= m_duty[0][i]);
      eb[i] = !force_off && (m_cnt <= m_duty[1][i]);
    end
    total++;
    if (chan_en_a !== ea || chan_en_b !== eb) begin
      bad++;
      $display("FAIL %s a=%h b=%h expected a=%h b=%h", tag, chan_en_a, chan_en_b, ea, eb);
    end
  endtask

  task automatic model_edge();
    bit term;
    int pend_n;
    pend_n = upd_valid ? int'(upd_div) : m_pend;
    term = ref_tick && (m_pre == m_act);
    if (term) begin
      m_act = pend_n;
      m_pre = 0;
      m_cnt = (m_cnt + 1) % 1024;
    end else if (ref_tick) begin
      m_pre++;
    end
    m_pend = pend_n;
    if (upd_valid) begin
      m_duty[0][upd_addr] = int'(upd_duty_a);
      m_duty[1][upd_addr] = int'(upd_duty_b);
    end
  endtask

  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ref_tick = (tick_mode == 0) ? 1'b1 : lfsr[0];
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    upd_valid = 1'b0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic update(int addr, int da, int db, int dv);
    upd_valid  = 1'b1;
    upd_addr   = 3'(addr);
    upd_duty_a = 10'(da);
    upd_duty_b = 10'(db);
    upd_div    = 4'(dv);
    step();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired in %s", tag);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; upd_valid = 1'b0; upd_addr = '0;
    upd_duty_a = '0; upd_duty_b = '0; upd_div = '0; force_off = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) m_duty[b][i] = 0;
    m_cnt = 0; m_pre = 0; m_act = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();
    run(2);

    tag = "R2";
    for (int i = 0; i < 8; i++) update(i, i * 120 + 40, 1000 - i * 110, 0);
    run(20);

    tag = "R5";
    run(1100);

    tag = "R4";
    update(3, 1023, 0, 0);
    update(5, 0, 1023, 0);
    run(1100);

    tag = "R3";
    for (int k = 0; k < 50; k++) update(2, k * 17, 1023 - k * 13, 0);
    run(1100);

    tag = "R6";
    tick_mode = 1;
    update(0, 300, 700, 3);
    run(9000);

    tag = "R7";
    update(1, 512, 256, 15);
    run(7);
    update(6, 900, 100, 15);
    run(20);
    update(7, 50, 950, 1);
    run(40000);

    tag = "R8";
    for (int k = 0; k < 60; k++) begin
      force_off = (k % 3 != 2);
      run(37);
    end
    force_off = 1'b0;
    run(500);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule